// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave port that gives a host serial access to a bank of 128 sixteen-bit configuration registers. The host frames each access with an active-low select. Every frame is 24 bits long. The first bit is a direction flag. The next seven bits give the register address, most significant first. The last sixteen bits carry the register word, most significant first. Input bits are taken on the rising edge of the serial clock. Read bits are launched on the falling edge, so the host can take each one on the following rising edge.

Read data can leave on one of two paths. In 3-wire mode it goes out on the shared data line: the block drives the output value and an output enable, and the pad cell lives outside the block. In 4-wire mode it goes out on a dedicated output, and the shared line is never driven. Two bits of the bank are decoded straight to output pins: an input bus width select (word-wide when 1) and a frame-parity enable. Raising the select before the frame is complete abandons the access.

Top module: `sreg_port`

## Requirements
- R1: After reset every register reads 0, both configuration outputs are 0, `sdio_oe` is 0 and `sdo` is 0.
- R2: A frame with direction bit 0 (write), address A6..A0 in bits 1..7 and data D15..D0 in bits 8..23 stores the data word in the addressed register.
- R3: A frame with direction bit 1 (read) returns the addressed register MSB first during bits 8..23. Each bit changes on a falling edge and is valid at the next rising edge.
- R4: A write is committed only on the 24th rising edge. Raising `cs_n` after 23 bits leaves the register unchanged.
- R5: Raising `cs_n` at any point clears the bit counter, so the next frame is decoded from its first bit.
- R6: In 3-wire mode (`four_wire`=0), `sdio_oe` is 1 only during the data bits of a read frame. `sdo` stays 0 throughout.
- R7: In 4-wire mode (`four_wire`=1), read data appears on `sdo` and `sdio_oe` stays 0.
- R8: `cfg_word_wide` follows bit 4 of register 0x03. Writes to other addresses leave it unchanged.
- R9: `cfg_parity_en` follows bit 2 of register 0x02.
- R10: Rising edges after the 24th bit of a frame are ignored until `cs_n` is raised. A read leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset of the whole port |
| cs_n | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Serial data from the shared line |
| sdio_o | output | 1 | Read data toward the shared-line pad |
| sdio_oe | output | 1 | Drive enable for the shared-line pad |
| sdo | output | 1 | Dedicated read-data output (4-wire mode) |
| four_wire | input | 1 | 1 selects the dedicated output for read data |
| cfg_word_wide | output | 1 | Input bus width select, register 0x03 bit 4 |
| cfg_parity_en | output | 1 | Frame-parity enable, register 0x02 bit 2 |

## Verification
The commit of a write and the abandoning of a frame can land on the same bit, so the bench ends write frames at exactly 23 and exactly 24 bits. A read-back then shows that only the complete frame changed the register. A frame cut after a few bits is followed at once by a clean frame, which must decode from its first bit. A 32-bit write must be stored with its first data word, proving that the later edges were ignored.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int HDR_W     = 1 + ADDR_W;
  localparam int FRAME_LEN = HDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int NREG      = 1 << ADDR_W;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // bit of the read word that leaves while the counter holds c
  function automatic logic [IDX_W-1:0] tx_index(input cnt_t c);
    int t;
    t = FRAME_LEN - 1 - int'(c);
    return IDX_W'(t);
  endfunction

  function automatic logic in_data_phase(input cnt_t c);
    return int'(c) >= HDR_W;
  endfunction
endpackage

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic  sclk,
  input  logic  frame_rst_n,
  input  logic  din,
  output cnt_t  cnt,
  output logic  rd_phase,
  output addr_t addr,
  output logic  wr_en,
  output word_t wr_data
);
  logic [DATA_W-2:0] shift_q;
  logic [HDR_W-1:0]  hdr_q;
  logic              frame_full;

  assign frame_full = (cnt == cnt_t'(FRAME_LEN));

  always_ff @(posedge sclk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      cnt     <= '0;
      shift_q <= '0;
      hdr_q   <= '0;
    end else if (!frame_full) begin
      cnt     <= cnt + 1'b1;
      shift_q <= {shift_q[DATA_W-3:0], din};
      if (cnt == cnt_t'(HDR_W - 1))
        hdr_q <= {shift_q[HDR_W-2:0], din};
    end
  end

  assign addr     = hdr_q[ADDR_W-1:0];
  assign rd_phase = hdr_q[HDR_W-1] && in_data_phase(cnt);
  assign wr_en    = !hdr_q[HDR_W-1] && (cnt == cnt_t'(FRAME_LEN - 1));
  assign wr_data  = {shift_q, din};

  // R10
  cnt_bound_chk: assert property (@(posedge sclk) disable iff (!frame_rst_n)
    int'(cnt) <= FRAME_LEN);
  // R4
  commit_last_chk: assert property (@(posedge sclk) disable iff (!frame_rst_n)
    wr_en |=> frame_full);
  // R2
  hdr_hold_chk: assert property (@(posedge sclk) disable iff (!frame_rst_n)
    in_data_phase(cnt) |=> $stable(hdr_q));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int WIDE_ADDR = 3,
  parameter int WIDE_BIT  = 4,
  parameter int PAR_ADDR  = 2,
  parameter int PAR_BIT   = 2
) (
  input  logic  sclk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t addr,
  input  word_t wr_data,
  output word_t rd_word,
  output logic  cfg_word_wide,
  output logic  cfg_parity_en
);
  word_t mem [NREG];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_word       = mem[addr];
  assign cfg_word_wide = mem[WIDE_ADDR][WIDE_BIT];
  assign cfg_parity_en = mem[PAR_ADDR][PAR_BIT];

  // checker state: the last committed write
  logic  chk_pend;
  addr_t chk_addr;
  word_t chk_data;
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pend <= 1'b0;
      chk_addr <= '0;
      chk_data <= '0;
    end else begin
      chk_pend <= wr_en;
      chk_addr <= addr;
      chk_data <= wr_data;
    end
  end

  // R2
  write_lands_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    chk_pend |-> mem[chk_addr] == chk_data);
  // R8
  wide_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_word_wide));
  // R9
  par_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_parity_en));
endmodule

// File: rtl/sreg_launch.sv
module sreg_launch
  import sreg_pkg::*;
(
  input  logic  sclk,
  input  logic  frame_rst_n,
  input  logic  four_wire,
  input  cnt_t  cnt,
  input  logic  rd_phase,
  input  word_t rd_word,
  output logic  sdio_o,
  output logic  sdio_oe,
  output logic  sdo
);
  logic bit_q;

  always_ff @(negedge sclk or negedge frame_rst_n) begin
    if (!frame_rst_n)
      bit_q <= 1'b0;
    else if (rd_phase && int'(cnt) < FRAME_LEN)
      bit_q <= rd_word[tx_index(cnt)];
  end

  assign sdio_o  = bit_q;
  assign sdio_oe = rd_phase && !four_wire;
  assign sdo     = (rd_phase && four_wire) ? bit_q : 1'b0;

  // R6
  oe_window_chk: assert property (@(posedge sclk) disable iff (!frame_rst_n)
    sdio_oe |-> in_data_phase(cnt));
  // R7
  sdo_quiet_chk: assert property (@(posedge sclk) disable iff (!frame_rst_n)
    !in_data_phase(cnt) |-> !sdo);
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int WIDE_ADDR = 3,
  parameter int WIDE_BIT  = 4,
  parameter int PAR_ADDR  = 2,
  parameter int PAR_BIT   = 2
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo,
  input  logic four_wire,
  output logic cfg_word_wide,
  output logic cfg_parity_en
);
  logic  frame_rst_n;
  cnt_t  cnt;
  logic  rd_phase;
  addr_t addr;
  logic  wr_en;
  word_t wr_data;
  word_t rd_word;

  // a raised select clears all frame state at once (R5)
  assign frame_rst_n = rst_n && !cs_n;

  sreg_frame u_frame (
    .sclk        (sclk),
    .frame_rst_n (frame_rst_n),
    .din         (sdio_i),
    .cnt         (cnt),
    .rd_phase    (rd_phase),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data)
  );

  sreg_bank #(
    .WIDE_ADDR (WIDE_ADDR),
    .WIDE_BIT  (WIDE_BIT),
    .PAR_ADDR  (PAR_ADDR),
    .PAR_BIT   (PAR_BIT)
  ) u_bank (
    .sclk          (sclk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wr_data       (wr_data),
    .rd_word       (rd_word),
    .cfg_word_wide (cfg_word_wide),
    .cfg_parity_en (cfg_parity_en)
  );

  sreg_launch u_launch (
    .sclk        (sclk),
    .frame_rst_n (frame_rst_n),
    .four_wire   (four_wire),
    .cnt         (cnt),
    .rd_phase    (rd_phase),
    .rd_word     (rd_word),
    .sdio_o      (sdio_o),
    .sdio_oe     (sdio_oe),
    .sdo         (sdo)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !sdio_oe && !sdo);
endmodule

// File: tb/tb_sreg_port.sv
module tb_sreg_port;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sdio_i = 1'b0;
  logic four_wire = 1'b0;
  logic sdio_o, sdio_oe, sdo, cfg_word_wide, cfg_parity_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 sclk = ~sclk;

  sreg_port dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .four_wire(four_wire),
    .cfg_word_wide(cfg_word_wide), .cfg_parity_en(cfg_parity_en)
  );

  // {mode, address, data}: mode 1 = 4-wire
  localparam logic [23:0] VEC [6] = '{
    {1'b0, 7'h10, 16'hA5C3},
    {1'b1, 7'h11, 16'h0001},
    {1'b0, 7'h7F, 16'h8000},
    {1'b1, 7'h00, 16'hFFFF},
    {1'b0, 7'h40, 16'h1234},
    {1'b1, 7'h2A, 16'hBEEF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // nbits < 24 cuts the frame; nbits > 24 adds trailing ones
  task automatic xfer(input logic rw, input logic [6:0] a, input logic [15:0] d,
                      input int nbits, output logic [15:0] rd, output int bad);
    logic [23:0] fr;
    fr = {rw, a, d};
    rd = '0;
    bad = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge sclk);
      #1;
      cs_n = 1'b0;
      sdio_i = (i < 24) ? fr[23-i] : 1'b1;
      if (i < 24) begin
        if (i >= 8 && rw) rd[23-i] = four_wire ? sdo : sdio_o;
        if (sdio_oe !== (rw && i >= 8 && !four_wire)) bad++;
        if (!four_wire && sdo !== 1'b0) bad++;
      end
    end
    @(negedge sclk);
    #1;
    cs_n = 1'b1;
    sdio_i = 1'b0;
    #1;
    if (sdio_oe !== 1'b0) bad++;
  endtask

  initial begin
    logic [15:0] rd;
    int bad;
    #20;
    // R1 reset state
    check("R1 cfg_word_wide", {15'd0, cfg_word_wide}, 16'd0);
    check("R1 cfg_parity_en", {15'd0, cfg_parity_en}, 16'd0);
    check("R1 sdio_oe", {15'd0, sdio_oe}, 16'd0);
    check("R1 sdo", {15'd0, sdo}, 16'd0);
    rst_n = 1'b1;
    #10;
    xfer(1'b1, 7'h55, 16'h0, 24, rd, bad);
    check("R1 register reads zero", rd, 16'h0000);

    // vector walk: write then read back in the listed mode
    foreach (VEC[k]) begin
      four_wire = VEC[k][23];
      xfer(1'b0, VEC[k][22:16], VEC[k][15:0], 24, rd, bad);
      check(four_wire ? "R7 write enable" : "R6 write enable", bad[15:0], 16'd0);
      xfer(1'b1, VEC[k][22:16], 16'h0, 24, rd, bad);
      check("R2 R3 read back", rd, VEC[k][15:0]);
      check(four_wire ? "R7 read pins" : "R6 read pins", bad[15:0], 16'd0);
    end
    four_wire = 1'b0;

    // R4 commit only on bit 24
    xfer(1'b0, 7'h10, 16'h5555, 23, rd, bad);
    xfer(1'b1, 7'h10, 16'h0, 24, rd, bad);
    check("R4 23-bit write dropped", rd, 16'hA5C3);
    xfer(1'b0, 7'h10, 16'h5555, 24, rd, bad);
    xfer(1'b1, 7'h10, 16'h0, 24, rd, bad);
    check("R4 24-bit write taken", rd, 16'h5555);

    // R5 short abort, then a clean frame
    xfer(1'b1, 7'h7F, 16'h0, 5, rd, bad);
    xfer(1'b0, 7'h33, 16'hC0DE, 24, rd, bad);
    xfer(1'b1, 7'h33, 16'h0, 24, rd, bad);
    check("R5 frame after abort", rd, 16'hC0DE);

    // R8 / R9 configuration taps
    xfer(1'b0, 7'h03, 16'h0010, 24, rd, bad);
    check("R8 word-wide set", {15'd0, cfg_word_wide}, 16'd1);
    check("R9 parity unaffected", {15'd0, cfg_parity_en}, 16'd0);
    xfer(1'b0, 7'h04, 16'hFFFF, 24, rd, bad);
    check("R8 other address ignored", {15'd0, cfg_word_wide}, 16'd1);
    xfer(1'b0, 7'h02, 16'h0004, 24, rd, bad);
    check("R9 parity set", {15'd0, cfg_parity_en}, 16'd1);
    xfer(1'b0, 7'h03, 16'hFFEF, 24, rd, bad);
    check("R8 word-wide clear", {15'd0, cfg_word_wide}, 16'd0);

    // R10 trailing bits ignored, read is side-effect free
    xfer(1'b0, 7'h21, 16'h0F0F, 32, rd, bad);
    xfer(1'b1, 7'h21, 16'h0, 24, rd, bad);
    check("R10 long frame stores first word", rd, 16'h0F0F);
    xfer(1'b1, 7'h21, 16'h0, 24, rd, bad);
    check("R10 second read unchanged", rd, 16'h0F0F);
    four_wire = 1'b1;
    xfer(1'b1, 7'h21, 16'h0, 30, rd, bad);
    check("R10 R7 long read", rd, 16'h0F0F);
    check("R7 long read pins", bad[15:0], 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule